// File: doc/BRIEF.md
# SDRAM Command Front End with Bank Tracking

This block models the device side of a two-bank synchronous DRAM and checks the protocol it receives. On every rising clock edge it samples the select, the three strobes, clock enable, a 12-bit address, two byte masks and a 16-bit write word. From these it works out the command, keeps an open or closed state and an open row for each bank, and holds a burst-length setting that only a valid mode word can change. It steps column bursts through a small behavioural storage array and returns read data with a fixed two-cycle access latency. A controller under development, or a system model, connects to it in place of a real memory. Any command that breaks the bank rules raises a one-cycle error pulse.

Reads and writes run as bursts of four or eight columns. The burst walks through the aligned block of columns that holds the start column and wraps around inside it. Clock enable freezes the whole block, outputs included. Byte masks gate write data in the same cycle they are sampled. Electrical timing, refresh retention and analog precharge behaviour are not modelled.

Top module: `sdram_cmd_front`

## Requirements
- R1: When cs_n is low on a processed edge, {ras_n,cas_n,we_n} selects the command: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. addr[11] selects the bank (1 = bank 1, 0 = bank 0). A precharge with addr[10]=1 closes both banks; with addr[10]=0 it closes only the selected bank.
- R2: A mode set is valid when addr[2:1]=01, addr[3]=0, addr[6:4]=010 and addr[9:7]=000. A valid word sets the burst length to 8 if addr[0]=1 and to 4 if addr[0]=0. An invalid word leaves the setting unchanged. The length after reset is 4. addr[11:10] are ignored.
- R3: An activate to an open bank, or a read or write to a closed bank, raises err and is otherwise ignored. In particular the row that is already open stays open.
- R4: A refresh or a mode set while either bank is open raises err and has no effect. With both banks closed, a refresh raises no error.
- R5: A write takes data on its command edge and on the following burst-length-minus-one processed edges. Beat k of any burst uses column {start[C-1:L], start[L-1:0]+k}, with L = 2 for bursts of 4 and L = 3 for bursts of 8.
- R6: On each write data edge, dqm_lo=1 keeps bits 7:0 of the stored word and dqm_hi=1 keeps bits 15:8. There is no latency.
- R7: For a read sampled at edge n, beat k is driven on rdata with rdata_oe=1 from edge n+1+k, so a controller captures it at edge n+2+k. After the last beat rdata_oe stays low until the next read delivers data.
- R8: With cs_n high the strobes are ignored. A burst already in progress continues.
- R9: The block acts on edge n only if cke was high at edge n-1. On any other edge no input is taken, the burst does not advance, and rdata and rdata_oe hold their values.
- R10: A read or write with addr[10]=1 closes its bank when its last beat completes, so a later activate of that bank is legal.
- R11: A burst stop ends the current burst. rdata_oe is low after the stop edge.
- R12: A new read keeps a running read going until the read's own edge, so reads issued burst-length cycles apart give gapless data. A write or a stop cancels any running burst at once. A read cancels a running write.
- R13: A falling clock enable (cke low at edge n, high at n-1) on the edge right after the last data beat of a write raises err.
- R14: err is a registered pulse that is high for the cycle after each offending edge. After reset err and rdata_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| addr | input | 12 | Row, column, bank select, auto-close flag or mode word |
| dqm_lo | input | 1 | Write mask for bits 7:0 |
| dqm_hi | input | 1 | Write mask for bits 15:8 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| rdata_oe | output | 1 | Read data valid (drive enable) |
| err | output | 1 | Illegal-command pulse |

## Verification
Bursts are run with start columns at the head and in the middle of an aligned block, under both burst lengths. This separates a linear column count from the wrapped order. Reads issued burst-length cycles apart show whether back-to-back reads are gapless, and a write landing in the middle of a read shows whether the read is cut off. Mask patterns that change on every beat tell zero-latency masking apart from masking that lags a cycle. Clock-enable pulses, given in the middle of a read, in the middle of a write and on the edge after a write's last beat, test the freeze and the resume offset, and show where suspending becomes illegal.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;

    typedef enum logic [2:0] {
        CMD_MRS   = 3'b000,
        CMD_REFR  = 3'b001,
        CMD_PRE   = 3'b010,
        CMD_ACTV  = 3'b011,
        CMD_WRITE = 3'b100,
        CMD_READ  = 3'b101,
        CMD_STOP  = 3'b110,
        CMD_NOP   = 3'b111
    } cmd_e;

    // Legal mode word: burst 4 or 8, serial order, latency 2, reserved bits clear
    function automatic logic mode_word_ok(input logic [9:0] w);
        return (w[2:1] == 2'b01) && (w[6:3] == 4'b0100) && (w[9:7] == 3'b000);
    endfunction

endpackage

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
    import sdram_fe_pkg::*;
(
    input  logic take,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (take && !cs_n) begin
            cmd = cmd_e'({ras_n, cas_n, we_n});
        end
    end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
    parameter int COL_BITS = 4
) (
    input  logic [COL_BITS-1:0] base,
    input  logic [3:0]          beat,
    input  logic                bl8,
    output logic [COL_BITS-1:0] col
);
    always_comb begin
        col = base;
        if (bl8) begin
            col[2:0] = base[2:0] + beat[2:0];
        end else begin
            col[1:0] = base[1:0] + beat[1:0];
        end
    end
endmodule

// File: rtl/sdram_store.sv
module sdram_store #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [IDX_W-1:0]        waddr,
    input  logic [DATA_W/8-1:0]     be,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [IDX_W-1:0]        raddr,
    output logic [DATA_W-1:0]       rdat
);
    localparam int NBYTE = DATA_W / 8;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < NBYTE; i++) begin
                if (be[i]) begin
                    mem[waddr][i*8 +: 8] <= wdata[i*8 +: 8];
                end
            end
        end
    end

    assign rdat = mem[raddr];
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_fe_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic        cke,
    input  logic [11:0] addr,
    input  logic        dqm_lo,
    input  logic        dqm_hi,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        rdata_oe,
    output logic        err
);
    localparam int DATA_W = 16;
    localparam int IDX_W  = 1 + ROW_BITS + COL_BITS;

    typedef struct packed {
        logic [1:0]                open;
        logic [1:0][ROW_BITS-1:0]  row;
        logic                      bl8;
        logic                      bact;
        logic                      bwr;
        logic                      bbank;
        logic                      bap;
        logic [ROW_BITS-1:0]       brow;
        logic [COL_BITS-1:0]       bcol;
        logic [3:0]                beat;
        logic [DATA_W-1:0]         rdat;
        logic                      roe;
        logic                      err;
        logic                      ckep;
        logic                      wrtail;
    } st_t;

    st_t st_q, st_d;

    cmd_e                cmd;
    logic                bsel;
    logic                is_rd, is_wr, is_stop;
    logic                step_en, last;
    logic [COL_BITS-1:0] step_col;
    logic [IDX_W-1:0]    raddr, waddr;
    logic [DATA_W-1:0]   rd_word;
    logic                mem_we;
    logic [1:0]          mem_be;

    sdram_cmd_dec u_dec (
        .take (st_q.ckep),
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    sdram_col_seq #(.COL_BITS(COL_BITS)) u_col (
        .base(st_q.bcol),
        .beat(st_q.beat),
        .bl8 (st_q.bl8),
        .col (step_col)
    );

    sdram_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(waddr),
        .be   (mem_be),
        .wdata(wdata),
        .raddr(raddr),
        .rdat (rd_word)
    );

    assign bsel    = addr[11];
    assign is_rd   = (cmd == CMD_READ);
    assign is_wr   = (cmd == CMD_WRITE);
    assign is_stop = (cmd == CMD_STOP);
    assign step_en = st_q.bact && !(is_wr || is_stop || (is_rd && st_q.bwr));
    assign last    = (st_q.beat == (st_q.bl8 ? 4'd7 : 4'd3));
    assign raddr   = {st_q.bbank, st_q.brow, step_col};

    always_comb begin
        st_d        = st_q;
        st_d.err    = 1'b0;
        st_d.wrtail = 1'b0;
        st_d.ckep   = cke;
        mem_we      = 1'b0;
        mem_be      = {~dqm_hi, ~dqm_lo};
        waddr       = raddr;
        if (st_q.ckep) begin
            st_d.roe  = 1'b0;
            st_d.rdat = '0;
            // burst engine: one beat per processed edge
            if (step_en) begin
                if (st_q.bwr) begin
                    mem_we = 1'b1;
                end else begin
                    st_d.roe  = 1'b1;
                    st_d.rdat = rd_word;
                end
                st_d.beat = st_q.beat + 4'd1;
                if (last) begin
                    st_d.bact   = 1'b0;
                    st_d.wrtail = st_q.bwr;
                    if (st_q.bap) begin
                        st_d.open[st_q.bbank] = 1'b0;
                    end
                end
            end else if (st_q.bact) begin
                st_d.bact = 1'b0;
            end
            // suspend request on the edge after the last write beat
            if (!cke && st_q.wrtail) begin
                st_d.err = 1'b1;
            end
            // command handling, against bank state after the engine step
            unique case (cmd)
                CMD_MRS: begin
                    if (|st_d.open) begin
                        st_d.err = 1'b1;
                    end else if (mode_word_ok(addr[9:0])) begin
                        st_d.bl8 = addr[0];
                    end
                end
                CMD_REFR: begin
                    if (|st_d.open) begin
                        st_d.err = 1'b1;
                    end
                end
                CMD_ACTV: begin
                    if (st_d.open[bsel]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.open[bsel] = 1'b1;
                        st_d.row[bsel]  = addr[ROW_BITS-1:0];
                    end
                end
                CMD_PRE: begin
                    if (addr[10]) begin
                        st_d.open = 2'b00;
                    end else begin
                        st_d.open[bsel] = 1'b0;
                    end
                end
                CMD_READ, CMD_WRITE: begin
                    if (!st_d.open[bsel]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.bact  = 1'b1;
                        st_d.bwr   = is_wr;
                        st_d.bbank = bsel;
                        st_d.brow  = st_d.row[bsel];
                        st_d.bcol  = addr[COL_BITS-1:0];
                        st_d.bap   = addr[10];
                        st_d.beat  = is_wr ? 4'd1 : 4'd0;
                        if (is_wr) begin
                            mem_we = 1'b1;
                            waddr  = {bsel, st_d.row[bsel], addr[COL_BITS-1:0]};
                        end
                    end
                end
                CMD_STOP: st_d.bact = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ckep <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdat;
    assign rdata_oe = st_q.roe;
    assign err      = st_q.err;

    AST_IDLE_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_rd || is_wr) && !st_q.open[bsel]) |=> err);  // R3
    AST_REOPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACTV && st_q.open[bsel] && !st_q.bact) |=> err);  // R3
    AST_BAD_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && !mode_word_ok(addr[9:0])) |=> $stable(st_q.bl8));  // R2
    AST_REFRESH_OPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REFR && (|st_q.open) && !st_q.bact) |=> err);  // R4
    AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ckep |=> ($stable(rdata) && $stable(rdata_oe) && !err));  // R9
    AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_oe) |-> $past(st_q.bact && !st_q.bwr));  // R7
endmodule

// File: tb/sim_sdram_cmd_front.sv
module sim_sdram_cmd_front;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [11:0] addr = '0;
    logic dqm_lo = 1'b0, dqm_hi = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic rdata_oe, err;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_cmd_front #(.ROW_BITS(2), .COL_BITS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .addr(addr), .dqm_lo(dqm_lo), .dqm_hi(dqm_hi),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .err(err));

    // behavioural reference state
    int m_bl = 4, m_row[2], m_bbank, m_brow, m_bcol, m_beat;
    bit m_open[2], m_bact, m_bwr, m_bap, m_oe, m_err, m_ckep = 1, m_tail;
    logic [15:0] m_rdat, ref_mem [0:127];

    function automatic int wcol(int base, int k);
        int w = (m_bl == 8) ? 7 : 3;
        return (base & ~w) | ((base + k) & w);
    endfunction

    function automatic void memw(int idx, logic [15:0] d, logic [1:0] m);
        if (!m[0]) ref_mem[idx][7:0] = d[7:0];
        if (!m[1]) ref_mem[idx][15:8] = d[15:8];
    endfunction

    function automatic void model(logic csn, logic [2:0] c, logic ck, logic [11:0] a,
                                  logic [1:0] m, logic [15:0] d);
        bit old_tail = m_tail;
        int b = int'(a[11]);
        bit isr = !csn && c == 3'b101, isw = !csn && c == 3'b100, iss = !csn && c == 3'b110;
        m_tail = 0;
        m_err = 0;
        if (m_ckep) begin
            m_oe = 0;
            if (m_bact) begin
                if (isw || iss || (isr && m_bwr)) m_bact = 0;
                else begin
                    int idx = m_bbank * 64 + m_brow * 16 + wcol(m_bcol, m_beat);
                    if (m_bwr) memw(idx, d, m);
                    else begin m_oe = 1; m_rdat = ref_mem[idx]; end
                    if (m_beat == m_bl - 1) begin
                        m_bact = 0;
                        if (m_bap) m_open[m_bbank] = 0;
                        if (m_bwr) m_tail = 1;
                    end
                    m_beat++;
                end
            end
            if (!ck && old_tail) m_err = 1;
            if (!csn) begin
                case (c)
                    3'b000: if (m_open[0] || m_open[1]) m_err = 1;
                            else if (a[2:1] == 2'b01 && a[6:3] == 4'b0100 && a[9:7] == 3'b000)
                                m_bl = a[0] ? 8 : 4;
                    3'b001: if (m_open[0] || m_open[1]) m_err = 1;
                    3'b011: if (m_open[b]) m_err = 1;
                            else begin m_open[b] = 1; m_row[b] = int'(a[1:0]); end
                    3'b010: if (a[10]) begin m_open[0] = 0; m_open[1] = 0; end
                            else m_open[b] = 0;
                    3'b100, 3'b101: if (!m_open[b]) m_err = 1;
                            else begin
                                m_bact = 1; m_bwr = isw; m_bbank = b; m_brow = m_row[b];
                                m_bcol = int'(a[3:0]); m_bap = a[10]; m_beat = 0;
                                if (isw) begin
                                    memw(b * 64 + m_brow * 16 + m_bcol, d, m);
                                    m_beat = 1;
                                end
                            end
                    3'b110: m_bact = 0;
                    default: ;
                endcase
            end
        end
        m_ckep = ck;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic csn, input logic [2:0] c, input logic ck, input logic [11:0] a,
                       input logic [1:0] m, input logic [15:0] d, input string tag);
        @(negedge clk);
        cs_n = csn; {ras_n, cas_n, we_n} = c; cke = ck; addr = a;
        {dqm_hi, dqm_lo} = m; wdata = d;
        @(posedge clk);
        model(csn, c, ck, a, m, d);
        #1;
        chk(tag, "oe", {15'd0, rdata_oe}, {15'd0, m_oe});
        chk(tag, "err", {15'd0, err}, {15'd0, m_err});
        if (m_oe) chk(tag, "rdata", rdata, m_rdat);
    endtask

    task automatic nop(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'd0, tag);
    endtask
    task automatic actv(input bit b, input int row, input string tag);
        cyc(0, 3'b011, 1, {b, 9'd0, 2'(row)}, 2'b00, 16'd0, tag);
    endtask
    task automatic rd(input bit b, input int col, input bit ap, input string tag);
        cyc(0, 3'b101, 1, {b, ap, 6'd0, 4'(col)}, 2'b00, 16'd0, tag);
    endtask
    task automatic wrb(input bit b, input int col, input bit ap, input int n, input logic [15:0] base,
                       input string tag);
        cyc(0, 3'b100, 1, {b, ap, 6'd0, 4'(col)}, 2'b00, base, tag);
        for (int k = 1; k < n; k++) cyc(0, 3'b111, 1, 12'd0, 2'b00, base + 16'(k * 16'h0111), tag);
    endtask
    task automatic mrs(input logic [11:0] w, input string tag);
        cyc(0, 3'b000, 1, w, 2'b00, 16'd0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R14 watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R14", "reset oe", {15'd0, rdata_oe}, 16'd0);
        chk("R14", "reset err", {15'd0, err}, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        nop(2, "R14");
        mrs(12'h022, "R2");
        actv(0, 1, "R1"); nop(1, "R1"); actv(1, 2, "R1"); nop(1, "R1");
        for (int c = 0; c < 16; c += 4) wrb(0, c, 0, 4, 16'h1000 + 16'(c * 16'h0101), "R5");
        for (int c = 0; c < 16; c += 4) wrb(1, c, 0, 4, 16'h8000 + 16'(c * 16'h0202), "R5");
        nop(1, "R5");
        rd(0, 1, 0, "R7"); nop(5, "R7");
        rd(0, 4, 0, "R12"); nop(3, "R12"); rd(1, 6, 0, "R12"); nop(5, "R12");
        mrs(12'h023, "R4"); rd(0, 0, 0, "R4"); nop(6, "R4");
        cyc(0, 3'b010, 1, 12'h400, 2'b00, 16'd0, "R10"); nop(1, "R10");
        mrs(12'h023, "R2"); nop(1, "R2");
        mrs(12'h0A2, "R2"); mrs(12'h222, "R2"); mrs(12'hC23, "R2"); nop(1, "R2");
        actv(0, 1, "R10"); actv(1, 2, "R10"); nop(1, "R10");
        rd(0, 5, 0, "R5"); nop(9, "R5");
        cyc(0, 3'b100, 1, 12'h008, 2'b01, 16'hA1B2, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b10, 16'hC3D4, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b11, 16'hE5F6, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'h0718, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b01, 16'h293A, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b10, 16'h4B5C, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'h6D7E, "R6");
        cyc(0, 3'b111, 1, 12'd0, 2'b11, 16'h8F90, "R6");
        nop(1, "R6"); rd(0, 8, 0, "R6"); nop(9, "R6");
        actv(0, 3, "R3"); nop(1, "R3");
        cyc(0, 3'b010, 1, 12'h800, 2'b00, 16'd0, "R1"); nop(1, "R1");
        rd(1, 0, 0, "R3"); wrb(1, 0, 0, 1, 16'h5555, "R3"); nop(1, "R3");
        cyc(0, 3'b001, 1, 12'd0, 2'b00, 16'd0, "R4"); nop(1, "R4");
        rd(0, 0, 0, "R8");
        cyc(1, 3'b011, 1, 12'h003, 2'b00, 16'd0, "R8");
        cyc(1, 3'b001, 1, 12'd0, 2'b00, 16'd0, "R8"); nop(8, "R8");
        rd(0, 0, 0, "R11"); nop(2, "R11");
        cyc(0, 3'b110, 1, 12'd0, 2'b00, 16'd0, "R11"); nop(3, "R11");
        rd(0, 8, 0, "R12"); nop(1, "R12"); wrb(0, 0, 0, 8, 16'h3300, "R12"); nop(3, "R12");
        rd(0, 0, 1, "R10"); nop(10, "R10"); actv(0, 1, "R10"); nop(2, "R10");
        rd(0, 0, 0, "R9");
        cyc(0, 3'b111, 0, 12'd0, 2'b00, 16'd0, "R9");
        cyc(0, 3'b111, 0, 12'd0, 2'b00, 16'd0, "R9");
        nop(10, "R9");
        cyc(0, 3'b100, 1, 12'h004, 2'b00, 16'h7000, "R9");
        cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'h7111, "R9");
        cyc(0, 3'b111, 0, 12'd0, 2'b00, 16'h7222, "R9");
        cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'hDEAD, "R9");
        for (int k = 3; k < 9; k++) cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'h7000 + 16'(k * 16'h0111), "R9");
        nop(2, "R9"); rd(0, 0, 0, "R9"); nop(10, "R9");
        wrb(0, 8, 0, 8, 16'h6000, "R13");
        cyc(0, 3'b111, 0, 12'd0, 2'b00, 16'd0, "R13");
        cyc(0, 3'b111, 1, 12'd0, 2'b00, 16'd0, "R13"); nop(3, "R13");
        cyc(0, 3'b010, 1, 12'h400, 2'b00, 16'd0, "R4"); nop(1, "R4");
        cyc(0, 3'b001, 1, 12'd0, 2'b00, 16'd0, "R4"); nop(2, "R4");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule